// File: doc/BRIEF.md
# ROM Shadow RAM Mapper

This block sits between a processor's memory request lines and the memory of an add-in processor card. For every read or write it decides where the access goes. There are three possible targets: a reserved 128 KB region at the bottom of the card's RAM, the system ROM and bus path, or nowhere. Two ROM areas can be shadowed. The first is the system BIOS at F0000h–FFFFFh. The second is the video ROM at C0000h–CFFFFh. Each has its own mapping mode, chosen from a small mode register.

One mode, called steered, works with a single shadow-enable bit. While that bit is clear, writes to the ROM area fill the reserved RAM and reads still come from the ROM. Driver software can therefore copy the ROM onto itself. Once the bit is set, reads of the area are served from the reserved RAM and writes are discarded, so the copy behaves as ROM.

The reserved RAM can always be reached as plain read/write memory through a fixed high window at 5E0000h–5FFFFFh. The BIOS copy is the upper 64 KB of that window, and the video copy is the lower 64 KB. The block only decodes. RAM timing, the ROM itself and refresh belong elsewhere.

Top module: `shadow_mapper`

## Requirements
- R1: After reset both control bytes read back as 00h and every region is in the unmapped mode, so a read at F0000h asserts only the system select.
- R2: An I/O write to port 670h loads the shadow control byte, and a write to port 672h loads the region mode byte. An I/O read of either port returns the last value written. A write to any other port changes neither byte, and a read of any other port returns 00h.
- R3: Any read or write in 5E0000h–5FFFFFh selects the reserved RAM, whatever the control and mode bytes hold. The RAM address is mem_addr[16:0], and ram_we follows the write strobe.
- R4: In mode 00b (unmapped), reads and writes to a region assert only the system select.
- R5: In mode 01b (steered) with control bit 0 clear, a write to the region selects RAM with ram_we high, and a read asserts only the system select.
- R6: In mode 01b with control bit 0 set, a read of the region selects RAM, and a write asserts neither select and leaves ram_we low.
- R7: In mode 10b (read/write RAM), reads and writes to the region both select RAM, and ram_we follows the write strobe.
- R8: In mode 11b (write-protected RAM), reads of the region select RAM, and writes assert neither select and never raise ram_we.
- R9: The mode byte holds the BIOS region F0000h–FFFFFh mode in bits [1:0] and the video region C0000h–CFFFFh mode in bits [3:2]. For a region hit the RAM address is {bank, mem_addr[15:0]}, where bank is 1 for BIOS and 0 for video.
- R10: RAM select and system select are never both high. With no strobe, or for an address outside the window and both regions, nothing is selected. When both strobes are high, the write strobe wins.
- R11: Bits 7:1 of the shadow control byte are stored but do not change the routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, 00h when not addressed |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| mem_addr | input | 24 | Physical memory address |
| ram_sel | output | 1 | Select for the on-card reserved RAM |
| ram_we | output | 1 | Write enable to the reserved RAM |
| ram_addr | output | 17 | Offset into the reserved RAM |
| sys_sel | output | 1 | Select for the ROM / system bus path |

## Verification
The routing is exercised through a grid of cases. Every mode is tried with both a read and a write, in both the BIOS and the video region, and with the shadow bit both clear and set. This separates a swapped read/write path from a swapped mode code and from a swapped region field. Accesses at the first and last bytes of each region and window, at addresses just outside them, and with no strobe show whether the decode borders are right. Writes of junk to the upper control bits, and of control values to a neighbouring port, show that the extra bits have no effect and that port decode is exact. An asynchronous reset in the middle of a run shows the return to the unmapped state.

// File: rtl/shadow_map_pkg.sv
package shadow_map_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_STEER = 2'b01,
    MODE_RW    = 2'b10,
    MODE_WP    = 2'b11
  } region_mode_e;

  typedef struct packed {
    logic         hit;
    region_mode_e mode;
    logic         bank;
  } region_sel_t;

endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs #(
  parameter int IO_AW = 16,
  parameter int DW = 8,
  parameter logic [IO_AW-1:0] PORT_CTRL = 16'h0670,
  parameter logic [IO_AW-1:0] PORT_MODE = 16'h0672
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [DW-1:0]    io_wdata,
  output logic [DW-1:0]    io_rdata,
  output logic [DW-1:0]    ctrl_q,
  output logic [DW-1:0]    mode_q
);

  logic          ctrl_en, mode_en;
  logic [DW-1:0] ctrl_d, mode_d;

  // next-state
  always_comb begin
    ctrl_en = io_wr && (io_addr == PORT_CTRL);
    mode_en = io_wr && (io_addr == PORT_MODE);
    ctrl_d  = io_wdata;
    mode_d  = io_wdata;
  end

  // registers with written-out clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mode_q <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (mode_en) mode_q <= mode_d;
    end
  end

  // readback
  always_comb begin
    io_rdata = '0;
    if (io_rd) begin
      if (io_addr == PORT_CTRL)      io_rdata = ctrl_q;
      else if (io_addr == PORT_MODE) io_rdata = mode_q;
    end
  end

  p_ctrl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == PORT_CTRL) |=> (ctrl_q == $past(io_wdata)));

  p_mode_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == PORT_MODE) |=> (mode_q == $past(io_wdata)));

  p_other_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_wr || (io_addr != PORT_CTRL && io_addr != PORT_MODE))
      |=> ($stable(ctrl_q) && $stable(mode_q)));

endmodule

// File: rtl/shadow_region_decode.sv
module shadow_region_decode
  import shadow_map_pkg::*;
#(
  parameter int SEG_W = 8,
  parameter int NUM_REGIONS = 2,
  parameter logic [NUM_REGIONS*SEG_W-1:0] REGION_SEGS = {8'h0C, 8'h0F},
  parameter logic [NUM_REGIONS-1:0] REGION_BANKS = 2'b01,
  localparam int MODE_BITS = 2 * NUM_REGIONS
) (
  input  logic [SEG_W-1:0]     seg,
  input  logic [MODE_BITS-1:0] modes,
  output region_sel_t          rsel
);

  logic         [NUM_REGIONS-1:0] hit_v;
  region_mode_e                   mode_v [NUM_REGIONS];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    assign hit_v[g]  = (seg == REGION_SEGS[g*SEG_W +: SEG_W]);
    assign mode_v[g] = region_mode_e'(modes[2*g +: 2]);
  end

  // lowest index wins if regions were ever configured to overlap
  always_comb begin
    rsel = '{hit: 1'b0, mode: MODE_OFF, bank: 1'b0};
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hit_v[i]) begin
        rsel.hit  = 1'b1;
        rsel.mode = mode_v[i];
        rsel.bank = REGION_BANKS[i];
      end
    end
  end

  a_onehot_regions_r9: assert final ($onehot0(hit_v));

endmodule

// File: rtl/shadow_route.sv
module shadow_route
  import shadow_map_pkg::*;
#(
  parameter int RAM_AW = 17,
  localparam int OFS_W = RAM_AW - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic              win_hit,
  input  logic [RAM_AW-1:0] win_ofs,
  input  region_sel_t       rsel,
  input  logic              shadow_en,
  output logic              ram_sel,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              sys_sel
);

  logic is_wr, is_rd;

  always_comb begin
    is_wr    = mem_wr;
    is_rd    = mem_rd && !mem_wr;
    ram_sel  = 1'b0;
    ram_we   = 1'b0;
    sys_sel  = 1'b0;
    ram_addr = '0;
    if (is_wr || is_rd) begin
      if (win_hit) begin
        ram_sel  = 1'b1;
        ram_we   = is_wr;
        ram_addr = win_ofs;
      end else if (rsel.hit) begin
        ram_addr = {rsel.bank, win_ofs[OFS_W-1:0]};
        unique case (rsel.mode)
          MODE_OFF: sys_sel = 1'b1;
          MODE_STEER: begin
            if (shadow_en) begin
              ram_sel = is_rd;
            end else begin
              ram_sel = is_wr;
              ram_we  = is_wr;
              sys_sel = is_rd;
            end
          end
          MODE_RW: begin
            ram_sel = 1'b1;
            ram_we  = is_wr;
          end
          MODE_WP: ram_sel = is_rd;
          default: sys_sel = 1'b1;
        endcase
      end
    end
  end

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sel |-> !sys_sel);

  p_we_needs_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_sel && mem_wr));

  p_wp_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_hit && rsel.hit && rsel.mode == MODE_WP && mem_wr) |-> !ram_we);

  p_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && (mem_rd || mem_wr)) |-> (ram_sel && ram_addr == win_ofs));

  p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_hit && rsel.hit && rsel.mode == MODE_STEER && shadow_en && mem_wr)
      |-> (!ram_sel && !sys_sel));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd && !mem_wr) |-> (!ram_sel && !sys_sel && !ram_we));

endmodule

// File: rtl/shadow_mapper.sv
module shadow_mapper
  import shadow_map_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IO_AW = 16,
  parameter int DW = 8,
  parameter int RAM_AW = 17,
  parameter int NUM_REGIONS = 2,
  parameter logic [IO_AW-1:0] PORT_CTRL = 16'h0670,
  parameter logic [IO_AW-1:0] PORT_MODE = 16'h0672,
  parameter logic [ADDR_W-RAM_AW-1:0] WIN_BASE = 7'h2F,
  parameter logic [NUM_REGIONS*(ADDR_W-16)-1:0] REGION_SEGS = {8'h0C, 8'h0F},
  parameter logic [NUM_REGIONS-1:0] REGION_BANKS = 2'b01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [DW-1:0]     io_wdata,
  output logic [DW-1:0]     io_rdata,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic              ram_sel,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              sys_sel
);

  localparam int SEG_W = ADDR_W - 16;
  localparam int MODE_BITS = 2 * NUM_REGIONS;

  logic [1:0]    rst_sync;
  logic          rst_n_s;
  logic [DW-1:0] ctrl_q, mode_q;
  logic          win_hit;
  region_sel_t   rsel;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  shadow_cfg_regs #(
    .IO_AW(IO_AW), .DW(DW), .PORT_CTRL(PORT_CTRL), .PORT_MODE(PORT_MODE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_s), .io_wr(io_wr), .io_rd(io_rd),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .ctrl_q(ctrl_q), .mode_q(mode_q)
  );

  assign win_hit = (mem_addr[ADDR_W-1:RAM_AW] == WIN_BASE);

  shadow_region_decode #(
    .SEG_W(SEG_W), .NUM_REGIONS(NUM_REGIONS),
    .REGION_SEGS(REGION_SEGS), .REGION_BANKS(REGION_BANKS)
  ) u_dec (
    .seg(mem_addr[ADDR_W-1:16]), .modes(mode_q[MODE_BITS-1:0]), .rsel(rsel)
  );

  shadow_route #(.RAM_AW(RAM_AW)) u_route (
    .clk(clk), .rst_n(rst_n_s), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .win_hit(win_hit), .win_ofs(mem_addr[RAM_AW-1:0]), .rsel(rsel),
    .shadow_en(ctrl_q[0]), .ram_sel(ram_sel), .ram_we(ram_we),
    .ram_addr(ram_addr), .sys_sel(sys_sel)
  );

  p_reset_unmapped_r1: assert property (@(posedge clk)
    (!rst_n_s && mem_rd && !mem_wr && rsel.hit) |-> (sys_sel && !ram_sel));

endmodule

// File: tb/sim_shadow_mapper.sv
`timescale 1ns/1ps
module sim_shadow_mapper;

  logic        clk, rst_n;
  logic        io_wr, io_rd;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata, io_rdata;
  logic        mem_rd, mem_wr;
  logic [23:0] mem_addr;
  logic        ram_sel, ram_we, sys_sel;
  logic [16:0] ram_addr;

  int checks = 0;
  int failures = 0;

  shadow_mapper u0 (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .ram_sel(ram_sel), .ram_we(ram_we),
    .ram_addr(ram_addr), .sys_sel(sys_sel)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {req, ctrl, mode, rd, wr, addr, e_ram, e_sys, e_we, e_addr}
  localparam int NV = 22;
  localparam logic [65:0] TBL [NV] = '{
    {4'd4,  8'h00, 8'h00, 1'b1, 1'b0, 24'h0F1234, 1'b0, 1'b1, 1'b0, 17'h00000}, // R4
    {4'd4,  8'h00, 8'h00, 1'b0, 1'b1, 24'h0C0010, 1'b0, 1'b1, 1'b0, 17'h00000}, // R4
    {4'd5,  8'h00, 8'h01, 1'b0, 1'b1, 24'h0F0100, 1'b1, 1'b0, 1'b1, 17'h10100}, // R5
    {4'd5,  8'h00, 8'h01, 1'b1, 1'b0, 24'h0F0100, 1'b0, 1'b1, 1'b0, 17'h00000}, // R5
    {4'd6,  8'h01, 8'h01, 1'b1, 1'b0, 24'h0FFFFF, 1'b1, 1'b0, 1'b0, 17'h1FFFF}, // R6
    {4'd6,  8'h01, 8'h01, 1'b0, 1'b1, 24'h0FFFFF, 1'b0, 1'b0, 1'b0, 17'h00000}, // R6
    {4'd7,  8'h00, 8'h02, 1'b1, 1'b0, 24'h0F8000, 1'b1, 1'b0, 1'b0, 17'h18000}, // R7
    {4'd7,  8'h01, 8'h02, 1'b0, 1'b1, 24'h0F8000, 1'b1, 1'b0, 1'b1, 17'h18000}, // R7
    {4'd8,  8'h00, 8'h03, 1'b1, 1'b0, 24'h0F0002, 1'b1, 1'b0, 1'b0, 17'h10002}, // R8
    {4'd8,  8'h00, 8'h03, 1'b0, 1'b1, 24'h0F0002, 1'b0, 1'b0, 1'b0, 17'h00000}, // R8
    {4'd9,  8'h01, 8'h04, 1'b1, 1'b0, 24'h0C4321, 1'b1, 1'b0, 1'b0, 17'h04321}, // R9
    {4'd9,  8'h00, 8'h08, 1'b0, 1'b1, 24'h0CFFFF, 1'b1, 1'b0, 1'b1, 17'h0FFFF}, // R9
    {4'd9,  8'h00, 8'h0C, 1'b1, 1'b0, 24'h0F0000, 1'b0, 1'b1, 1'b0, 17'h00000}, // R9
    {4'd9,  8'h00, 8'h03, 1'b1, 1'b0, 24'h0C0000, 1'b0, 1'b1, 1'b0, 17'h00000}, // R9
    {4'd3,  8'h01, 8'h0F, 1'b0, 1'b1, 24'h5E1234, 1'b1, 1'b0, 1'b1, 17'h01234}, // R3
    {4'd3,  8'h00, 8'h00, 1'b1, 1'b0, 24'h5FABCD, 1'b1, 1'b0, 1'b0, 17'h1ABCD}, // R3
    {4'd3,  8'h00, 8'h0F, 1'b1, 1'b0, 24'h5F0000, 1'b1, 1'b0, 1'b0, 17'h10000}, // R3
    {4'd10, 8'h00, 8'h0A, 1'b1, 1'b0, 24'h100000, 1'b0, 1'b0, 1'b0, 17'h00000}, // R10
    {4'd10, 8'h00, 8'h0A, 1'b1, 1'b0, 24'h5DFFFF, 1'b0, 1'b0, 1'b0, 17'h00000}, // R10
    {4'd10, 8'h00, 8'h01, 1'b1, 1'b1, 24'h0F0040, 1'b1, 1'b0, 1'b1, 17'h10040}, // R10
    {4'd11, 8'hFE, 8'h01, 1'b0, 1'b1, 24'h0F0010, 1'b1, 1'b0, 1'b1, 17'h10010}, // R11
    {4'd11, 8'hFE, 8'h01, 1'b1, 1'b0, 24'h0F0010, 1'b0, 1'b1, 1'b0, 17'h00000}  // R11
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] port, input logic [7:0] val);
    @(negedge clk);
    io_wr = 1'b1; io_addr = port; io_wdata = val;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read_chk(input string req, input logic [15:0] port,
                             input logic [7:0] exp);
    @(negedge clk);
    io_rd = 1'b1; io_addr = port;
    #1;
    chk(req, "io_rdata", {24'h0, io_rdata}, {24'h0, exp});
    io_rd = 1'b0;
  endtask

  task automatic access_chk(input string req, input logic rd, input logic wr,
                            input logic [23:0] a, input logic e_ram,
                            input logic e_sys, input logic e_we,
                            input logic [16:0] e_addr);
    @(negedge clk);
    mem_rd = rd; mem_wr = wr; mem_addr = a;
    #1;
    chk(req, "ram_sel", {31'h0, ram_sel}, {31'h0, e_ram});
    chk(req, "sys_sel", {31'h0, sys_sel}, {31'h0, e_sys});
    chk(req, "ram_we",  {31'h0, ram_we},  {31'h0, e_we});
    if (e_ram) chk(req, "ram_addr", {15'h0, ram_addr}, {15'h0, e_addr});
    mem_rd = 1'b0; mem_wr = 1'b0;
  endtask

  initial begin
    #(5.0 * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; io_wr = 1'b0; io_rd = 1'b0; io_addr = '0; io_wdata = '0;
    mem_rd = 1'b0; mem_wr = 1'b0; mem_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    io_read_chk("R1", 16'h0670, 8'h00);
    io_read_chk("R1", 16'h0672, 8'h00);
    access_chk("R1", 1'b1, 1'b0, 24'h0F0000, 1'b0, 1'b1, 1'b0, 17'h0);
    access_chk("R1", 1'b1, 1'b0, 24'h0C8000, 1'b0, 1'b1, 1'b0, 17'h0);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", TBL[i][65:62]);
      io_write(16'h0670, TBL[i][61:54]);
      io_write(16'h0672, TBL[i][53:46]);
      access_chk(tag, TBL[i][45], TBL[i][44], TBL[i][43:20],
                 TBL[i][19], TBL[i][18], TBL[i][17], TBL[i][16:0]);
    end

    // R10: idle strobes
    io_write(16'h0672, 8'h0A);
    access_chk("R10", 1'b0, 1'b0, 24'h0F0000, 1'b0, 1'b0, 1'b0, 17'h0);
    access_chk("R10", 1'b0, 1'b0, 24'h5E0000, 1'b0, 1'b0, 1'b0, 17'h0);

    // R2: readback and neighbour-port isolation
    io_write(16'h0670, 8'hA5);
    io_write(16'h0672, 8'h5A);
    io_read_chk("R2", 16'h0670, 8'hA5);
    io_read_chk("R2", 16'h0672, 8'h5A);
    io_write(16'h0671, 8'h3C);
    io_write(16'h0673, 8'hC3);
    io_read_chk("R2", 16'h0670, 8'hA5);
    io_read_chk("R2", 16'h0672, 8'h5A);
    io_read_chk("R2", 16'h0671, 8'h00);
    // mode 0x5A: BIOS bits[1:0]=10 (RW); routing unchanged by neighbour write
    access_chk("R2", 1'b0, 1'b1, 24'h0F0004, 1'b1, 1'b0, 1'b1, 17'h10004);

    // R11: upper control bits only, shadow bit clear -> steered write path
    io_write(16'h0672, 8'h01);
    io_write(16'h0670, 8'h80);
    access_chk("R11", 1'b1, 1'b0, 24'h0F0020, 1'b0, 1'b1, 1'b0, 17'h0);
    io_read_chk("R11", 16'h0670, 8'h80);

    // R1: asynchronous reset in the middle of a run
    io_write(16'h0670, 8'h01);
    io_write(16'h0672, 8'h0F);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    io_read_chk("R1", 16'h0670, 8'h00);
    io_read_chk("R1", 16'h0672, 8'h00);
    access_chk("R1", 1'b1, 1'b0, 24'h0FFFFF, 1'b0, 1'b1, 1'b0, 17'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    access_chk("R1", 1'b0, 1'b1, 24'h0C0000, 1'b0, 1'b1, 1'b0, 17'h0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule